// File: doc/BRIEF.md
# Dual-Lane Serial Flash Read Master

This block fetches calibration data, such as stored column noise tables, from an external serial flash. A client presents a 24-bit start address, a byte count and a strobe on a valid/ready request port. The block then runs one chip-select frame with four phases: an 8-bit read command, the address, optional mode bits and dummy clocks, and the data return. The bytes come back in address order on a valid/ready stream.

Two read variants are supported, and the mode input selects one when a request is accepted. The address-on-both-lines variant sends command 0xBB. It puts the address on both data lines, two bits per clock, and follows it with 4 clocks of mode bits and 4 dummy clocks. The address-on-one-line variant sends command 0x3B. It puts the address on line 0 only and follows it with 8 dummy clocks. In both variants the flash returns data on both lines. The master releases both line drivers before the first dummy clock. The serial clock is the system clock divided by the even parameter `CLK_DIV`. It idles low, and data is sampled on its rising edge (SPI mode 0).

Top module: `dual_spi_rd_master`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, both output enables are low, rd_valid is low and req_ready is high.
- R2: The serial clock toggles only while chip select is low. Each high pulse lasts exactly CLK_DIV/2 system clocks. Each low pulse lasts at least CLK_DIV/2 system clocks, and the clock is low whenever chip select is high.
- R3: Each frame starts with 8 clocks of command on line 0, MSB first, with only line 0 driven. The command is 0xBB when mode_sel=1 and 0x3B when mode_sel=0.
- R4: With mode_sel=1, the 24-bit address takes 12 clocks, MSB first, with line 1 carrying the higher bit of each pair. It is followed by 4 clocks of mode bits with value 0x00 driven on both lines, then 4 dummy clocks.
- R5: With mode_sel=0, the address takes 24 clocks on line 0, MSB first, followed by 8 dummy clocks. Line 1 is never driven in this mode.
- R6: Both output enables are low from the first dummy clock to the end of the frame.
- R7: Each data byte takes 4 clocks. In each clock, line 1 carries the higher bit and line 0 the lower bit, and the first pair is bits 7:6. Bytes appear on rd_data in address order, one per rd_valid/rd_ready handshake.
- R8: While rd_valid is high and rd_ready is low, rd_data and rd_valid hold. The serial clock pauses so that no byte is lost or overwritten.
- R9: A frame has exactly 28+4N clocks with mode_sel=1 and 40+4N clocks with mode_sel=0, where N is req_len. Chip select rises at the end of the last clock.
- R10: After chip select rises, it stays high for at least CSH_MIN system clocks. req_ready is low until that time has passed.
- R11: A request with req_len=0 is accepted but starts no frame. Chip select stays high and no byte is returned.
- R12: The mode and address are captured at acceptance. Changing mode_sel during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | 1: address on both lines (0xBB), 0: address on line 0 (0x3B) |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes to read |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_data | output | 8 | Returned byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| io0_o | output | 1 | Line 0 output value |
| io0_oe | output | 1 | Line 0 output enable |
| io0_i | input | 1 | Line 0 input value |
| io1_o | output | 1 | Line 1 output value |
| io1_oe | output | 1 | Line 1 output enable |
| io1_i | input | 1 | Line 1 input value |

## Verification
The hardest case to reach is a consumer stall that arrives exactly when the last pair of a byte is due while the previous byte is still waiting. Only then must the serial clock freeze in its low phase. The bench drives rd_ready from a sparse pseudo-random pattern during long reads in both modes, so this collision happens many times. A behavioural flash model checks that every byte still comes back intact. Back-to-back requests issued the moment req_ready rises test the minimum deselect time, and a mode flip just after acceptance tests that the mode is held for the whole frame.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA,
        PH_GAP
    } phase_e;

    localparam logic [7:0] CMD_ADDR_DUAL = 8'hBB;
    localparam logic [7:0] CMD_ADDR_ONE  = 8'h3B;

    localparam int ADDR_W          = 24;
    localparam int CMD_CLKS        = 8;
    localparam int ADDR_CLKS_DUAL  = ADDR_W / 2;
    localparam int ADDR_CLKS_ONE   = ADDR_W;
    localparam int MODE_CLKS       = 4;
    localparam int DUMMY_CLKS_DUAL = 4;
    localparam int DUMMY_CLKS_ONE  = 8;
    localparam int BYTE_CLKS       = 4;

endpackage

// File: rtl/dspi_sck_gen.sv
module dspi_sck_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold_rise,
    output logic sck,
    output logic rise_evt,
    output logic fall_evt
);

    localparam int HALF = CLK_DIV / 2;
    localparam int DW   = $clog2(HALF) + 1;

    typedef struct packed {
        logic          sck;
        logic [DW-1:0] div;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        if (!run) begin
            st_d.sck = 1'b0;
            st_d.div = '0;
        end else if (st_q.div == DW'(HALF - 1)) begin
            if (st_q.sck) begin
                fall_evt = 1'b1;
                st_d.sck = 1'b0;
                st_d.div = '0;
            end else if (!hold_rise) begin
                rise_evt = 1'b1;
                st_d.sck = 1'b1;
                st_d.div = '0;
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck = st_q.sck;

    // R8
    hold_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hold_rise && !st_q.sck) |=> !st_q.sck);

endmodule

// File: rtl/dspi_rx_collect.sv
module dspi_rx_collect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic       last_pair,
    input  logic       io1_i,
    input  logic       io0_i,
    input  logic       rd_ready,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       stall
);

    typedef struct packed {
        logic [5:0] acc;
        logic [7:0] data;
        logic       valid;
    } rx_t;

    rx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && rd_ready) st_d.valid = 1'b0;
        if (capture) begin
            st_d.acc = {st_q.acc[3:0], io1_i, io0_i};
            if (last_pair) begin
                st_d.data  = {st_q.acc, io1_i, io0_i};
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;
    assign stall    = st_q.valid && !rd_ready;

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R8
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && last_pair) |-> !stall);

endmodule

// File: rtl/dual_spi_rd_master.sv
module dual_spi_rd_master
    import dspi_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int LEN_W   = 16,
    parameter int CSH_MIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [23:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              io0_o,
    output logic              io0_oe,
    input  logic              io0_i,
    output logic              io1_o,
    output logic              io1_oe,
    input  logic              io1_i
);

    localparam int SH_W = 8 + ADDR_W;
    localparam int CW   = $clog2(ADDR_CLKS_ONE);
    localparam int GW   = $clog2(CSH_MIN + 1);

    typedef struct packed {
        phase_e           phase;
        logic             mode;
        logic [SH_W-1:0]  sh;
        logic [CW-1:0]    cnt;
        logic [LEN_W-1:0] left;
        logic [GW-1:0]    gap;
        logic             cs_n;
    } seq_t;

    seq_t st_d, st_q;

    logic run, hold, rise, fall, capture, last_pair, stall, in_data;

    assign in_data   = (st_q.phase == PH_DATA);
    assign last_pair = (st_q.cnt == '0);
    assign run       = (st_q.phase != PH_IDLE) && (st_q.phase != PH_GAP);
    assign hold      = in_data && last_pair && stall;
    assign capture   = in_data && rise;

    dspi_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .hold_rise (hold),
        .sck       (spi_sck),
        .rise_evt  (rise),
        .fall_evt  (fall)
    );

    dspi_rx_collect u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .last_pair (last_pair),
        .io1_i     (io1_i),
        .io0_i     (io0_i),
        .rd_ready  (rd_ready),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .stall     (stall)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid && req_len != '0) begin
                    st_d.phase = PH_CMD;
                    st_d.mode  = mode_sel;
                    st_d.sh    = {mode_sel ? CMD_ADDR_DUAL : CMD_ADDR_ONE, req_addr};
                    st_d.cnt   = CW'(CMD_CLKS - 1);
                    st_d.left  = req_len;
                    st_d.cs_n  = 1'b0;
                end
            end
            PH_CMD: begin
                if (fall) begin
                    st_d.sh = st_q.sh << 1;
                    if (last_pair) begin
                        st_d.phase = PH_ADDR;
                        st_d.cnt   = st_q.mode ? CW'(ADDR_CLKS_DUAL - 1) : CW'(ADDR_CLKS_ONE - 1);
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
            PH_ADDR: begin
                if (fall) begin
                    st_d.sh = st_q.mode ? (st_q.sh << 2) : (st_q.sh << 1);
                    if (last_pair) begin
                        st_d.phase = st_q.mode ? PH_MODE : PH_DUMMY;
                        st_d.cnt   = st_q.mode ? CW'(MODE_CLKS - 1) : CW'(DUMMY_CLKS_ONE - 1);
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
            PH_MODE: begin
                if (fall) begin
                    st_d.sh = st_q.sh << 2;
                    if (last_pair) begin
                        st_d.phase = PH_DUMMY;
                        st_d.cnt   = CW'(DUMMY_CLKS_DUAL - 1);
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
            PH_DUMMY: begin
                if (fall) begin
                    if (last_pair) begin
                        st_d.phase = PH_DATA;
                        st_d.cnt   = CW'(BYTE_CLKS - 1);
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (rise && last_pair) st_d.left = st_q.left - 1'b1;
                if (fall) begin
                    if (last_pair) begin
                        if (st_q.left == '0) begin
                            st_d.phase = PH_GAP;
                            st_d.cs_n  = 1'b1;
                            st_d.gap   = '0;
                        end else begin
                            st_d.cnt = CW'(BYTE_CLKS - 1);
                        end
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
            PH_GAP: begin
                if (st_q.gap == GW'(CSH_MIN - 1)) st_d.phase = PH_IDLE;
                else                              st_d.gap   = st_q.gap + 1'b1;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.cs_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        io0_o  = 1'b0;
        io1_o  = 1'b0;
        io0_oe = 1'b0;
        io1_oe = 1'b0;
        unique case (st_q.phase)
            PH_CMD: begin
                io0_o  = st_q.sh[SH_W-1];
                io0_oe = 1'b1;
            end
            PH_ADDR, PH_MODE: begin
                io0_oe = 1'b1;
                if (st_q.mode) begin
                    io1_oe = 1'b1;
                    io1_o  = st_q.sh[SH_W-1];
                    io0_o  = st_q.sh[SH_W-2];
                end else begin
                    io0_o  = st_q.sh[SH_W-1];
                end
            end
            default: ;
        endcase
    end

    assign req_ready = (st_q.phase == PH_IDLE);
    assign spi_cs_n  = st_q.cs_n;

    // Assertion support: consecutive cycles with chip select high, saturating
    logic [GW-1:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             hi_cnt_q <= GW'(CSH_MIN);
        else if (!spi_cs_n)                     hi_cnt_q <= '0;
        else if (hi_cnt_q != GW'(CSH_MIN))      hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    // R10
    deselect_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt_q >= GW'(CSH_MIN)));

    // R2
    sck_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);

    // R5
    one_line_no_io1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && !st_q.mode) |-> !io1_oe);

    // R6
    data_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (!io0_oe && !io1_oe));

    // R11
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len == '0) |=> spi_cs_n);

endmodule

// File: tb/tb_dual_spi_rd_master.sv
module tb_dual_spi_rd_master;

    localparam int CLK_DIV = 4;
    localparam int HALF    = CLK_DIV / 2;
    localparam int LEN_W   = 16;
    localparam int CSH_MIN = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_sel = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             rd_valid;
    logic             rd_ready = 1'b1;
    logic [7:0]       rd_data;
    logic             spi_cs_n, spi_sck;
    logic             io0_o, io0_oe, io1_o, io1_oe;
    logic             fl_io0 = 1'b0, fl_io1 = 1'b0;

    always #10 clk = ~clk;

    dual_spi_rd_master #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .CSH_MIN(CSH_MIN)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .io0_o(io0_o), .io0_oe(io0_oe), .io0_i(fl_io0),
        .io1_o(io1_o), .io1_oe(io1_oe), .io1_i(fl_io1)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] flash_byte(input logic [23:0] a);
        return {a[3:0], a[7:4]} ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    // ---------------- behavioural flash ----------------
    int          fl_rises = 0;
    logic [7:0]  fl_cmd = '0;
    logic [23:0] fl_addr = '0;
    logic [7:0]  fl_mbits = '0;
    int          fl_oe_err = 0;
    int          fl_n, fl_k, fl_ds;
    logic [7:0]  fl_b;

    always @(negedge spi_cs_n) begin
        fl_rises = 0;
        fl_cmd   = '0;
        fl_addr  = '0;
        fl_mbits = '0;
    end

    always @(posedge spi_sck) begin
        fl_rises = fl_rises + 1;
        fl_n = fl_rises;
        if (fl_n <= 8) begin
            fl_cmd = {fl_cmd[6:0], io0_o};
            if (!io0_oe || io1_oe) fl_oe_err++;
        end else if (fl_cmd == 8'hBB) begin
            if (fl_n <= 20) begin
                fl_addr = {fl_addr[21:0], io1_o, io0_o};
                if (!io0_oe || !io1_oe) fl_oe_err++;
            end else if (fl_n <= 24) begin
                fl_mbits = {fl_mbits[5:0], io1_o, io0_o};
                if (!io0_oe || !io1_oe) fl_oe_err++;
            end else if (io0_oe || io1_oe) fl_oe_err++;
        end else begin
            if (fl_n <= 32) begin
                fl_addr = {fl_addr[22:0], io0_o};
                if (!io0_oe || io1_oe) fl_oe_err++;
            end else if (io0_oe || io1_oe) fl_oe_err++;
        end
    end

    always @(negedge spi_sck) begin
        fl_ds = (fl_cmd == 8'hBB) ? 29 : 41;
        if (fl_rises + 1 >= fl_ds) begin
            fl_k   = fl_rises + 1 - fl_ds;
            fl_b   = flash_byte(fl_addr + 24'(fl_k / 4));
            fl_io1 = fl_b[7 - 2 * (fl_k % 4)];
            fl_io0 = fl_b[6 - 2 * (fl_k % 4)];
        end
    end

    // ---------------- sampler / consumer ----------------
    logic [7:0] got [0:63];
    int   ngot = 0;
    bit   stall_mode = 1'b0;
    logic [7:0] lfsr = 8'hA7;
    int   hi_run = 0, cs_hi_run = 0, min_gap = 1000;
    int   sck_err = 0, hold_err = 0, gap_err = 0;
    bit   prev_stall = 1'b0, prev_cs = 1'b1, seen_low = 1'b0;
    logic [7:0] prev_data = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rd_ready = stall_mode ? (lfsr[0] & lfsr[2]) : 1'b1;
            if (prev_stall && (!rd_valid || rd_data != prev_data)) hold_err++;
            prev_stall = rd_valid && !rd_ready;
            prev_data  = rd_data;
            if (rd_valid && rd_ready) begin
                if (ngot < 64) got[ngot] = rd_data;
                ngot++;
            end
            if (spi_sck) hi_run++;
            else begin
                if (hi_run != 0 && hi_run != HALF) sck_err++;
                hi_run = 0;
            end
            if (spi_cs_n && spi_sck) sck_err++;
            if (spi_cs_n && !prev_cs && req_ready) gap_err++;
            if (spi_cs_n) cs_hi_run++;
            else begin
                if (seen_low && cs_hi_run != 0) begin
                    if (cs_hi_run < min_gap) min_gap = cs_hi_run;
                    if (cs_hi_run < CSH_MIN) gap_err++;
                end
                seen_low  = 1'b1;
                cs_hi_run = 0;
            end
            prev_cs = spi_cs_n;
        end
    end

    // ---------------- scenarios ----------------
    task automatic do_read(input bit m, input logic [23:0] a, input int len,
                           input bit stall, input bit flip, input string tag);
        int oe0 = fl_oe_err, sk0 = sck_err, hd0 = hold_err;
        int exp_rises = m ? (28 + 4 * len) : (40 + 4 * len);
        int w = 0;
        int bad = 0;
        stall_mode = stall;
        ngot = 0;
        while (!req_ready) @(negedge clk);
        mode_sel = m; req_addr = a; req_len = LEN_W'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) mode_sel = ~m;
        while (!(ngot >= len && spi_cs_n) && w < 20000) begin
            @(negedge clk);
            w++;
        end
        check(fl_cmd == (m ? 8'hBB : 8'h3B), "R3", {tag, " command"}, fl_cmd, m ? 8'hBB : 8'h3B);
        check(fl_addr == a, m ? "R4" : "R5", {tag, " address"}, fl_addr, a);
        if (m) check(fl_mbits == 8'h00, "R4", {tag, " mode bits"}, fl_mbits, 0);
        check(fl_rises == exp_rises, "R9", {tag, " clock count"}, fl_rises, exp_rises);
        check(ngot == len, "R9", {tag, " byte count"}, ngot, len);
        for (int i = 0; i < len && i < 64; i++)
            if (got[i] != flash_byte(a + 24'(i))) begin
                if (bad == 0) check(1'b0, "R7", {tag, " data byte"}, got[i], flash_byte(a + 24'(i)));
                bad++;
            end
        check(bad == 0, "R7", {tag, " data mismatches"}, bad, 0);
        check(fl_oe_err == oe0, m ? "R6" : "R5", {tag, " line direction errors"}, fl_oe_err - oe0, 0);
        check(sck_err == sk0, "R2", {tag, " sck pulse errors"}, sck_err - sk0, 0);
        check(hold_err == hd0, "R8", {tag, " hold errors"}, hold_err - hd0, 0);
        stall_mode = 1'b0;
    endtask

    task automatic t_reset;
        check(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
        check(!io0_oe && !io1_oe, "R1", "oe after reset", {io1_oe, io0_oe}, 0);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    endtask

    task automatic t_zero_len;
        int cs_low = 0, vals = 0;
        while (!req_ready) @(negedge clk);
        req_addr = 24'h000100; req_len = '0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (!spi_cs_n) cs_low++;
            if (rd_valid) vals++;
            @(negedge clk);
        end
        check(cs_low == 0, "R11", "cs low cycles on zero length", cs_low, 0);
        check(vals == 0, "R11", "bytes on zero length", vals, 0);
        check(req_ready == 1'b1, "R11", "ready after zero length", req_ready, 1);
    endtask

    task automatic t_back_to_back;
        int g0 = gap_err;
        min_gap = 1000;
        do_read(1'b1, 24'h00F0F0, 2, 1'b0, 1'b0, "b2b first");
        do_read(1'b0, 24'h00F0F2, 2, 1'b0, 1'b0, "b2b second");
        check(min_gap >= CSH_MIN, "R10", "minimum deselect cycles", min_gap, CSH_MIN);
        check(gap_err == g0, "R10", "deselect or ready errors", gap_err - g0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        do_read(1'b1, 24'h12A5C3, 5, 1'b0, 1'b0, "dual-addr");
        do_read(1'b0, 24'hFFFFFE, 4, 1'b0, 1'b0, "one-line wrap");
        do_read(1'b1, 24'h3C0001, 24, 1'b1, 1'b0, "dual-addr stall");
        do_read(1'b0, 24'h800000, 24, 1'b1, 1'b0, "one-line stall");
        do_read(1'b1, 24'h0ABCDE, 3, 1'b0, 1'b1, "R12 flip to one-line");
        do_read(1'b0, 24'h5A5A5A, 3, 1'b0, 1'b1, "R12 flip to dual-addr");
        t_zero_len;
        t_back_to_back;
        do_read(1'b1, 24'h000000, 1, 1'b0, 1'b0, "single byte");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule